// File: doc/BRIEF.md
# Multi-Context TLB Entry Matcher

This block decides the outcome of one memory access against a small, fully visible set of translation entries. Each entry carries a valid flag, a translation ID, an address-space bit, a page-size code, an effective page number, a real page number and six permission bits. Separate user and supervisor sets each hold read, write and execute. The block takes the effective address of a load, store or instruction fetch, together with the current process context. It then reports one of four results: a miss, a granted access with its real address, an access violation, or an execute violation.

The process context is either three process-ID registers or, for an external-context load or store, one substitute ID with its own address-space and privilege bits. All entries are compared in parallel. The lowest-numbered entry that matches decides the result. The result is registered, so it appears on the cycle after the request. Loading entries and choosing a set belong to the surrounding logic.

Top module: `tlb_mas_match`

## Requirements
- R1: Each cycle with `req_valid` high yields `res_valid` high on the next cycle. A cycle without a request yields `res_valid` low on the next cycle. `res_valid` is low out of reset.
- R2: An entry's page covers 1024 << size-code bytes. The effective address matches when it agrees with the entry page number on every bit above the page offset. On a grant, `res_ra` takes the real page number above the offset and the effective address within it.
- R3: When `ctx_wide` is low, effective-address bits 32 and up count as zero during the compare and in `res_ra`.
- R4: An entry whose translation ID is zero matches under any process context.
- R5: In the normal context, a non-zero translation ID matches if it equals `pid0`, or equals `pid1` while `pid1` is non-zero, or equals `pid2` while `pid2` is non-zero.
- R6: When `req_ext` is high on a load or store, the ID comes only from `ext_pid`, the address space from `ext_as` and the privilege from `ext_user`. In that case `pid0..2`, `ctx_dspace` and `ctx_user` have no effect.
- R7: An entry takes part only when its address-space bit equals the access's address space. For a fetch that is `ctx_ispace`; for data it is `ctx_dspace`, or `ext_as` for external-context data. An entry that fails this is skipped, and the search goes on.
- R8: Among the entries that pass R2, R3, R4, R5, R6 and R7 and are valid, the lowest index decides, and `res_index` reports it. On a miss, `res_index` is 0.
- R9: Permission bits are at these positions: [0] user read, [1] user write, [2] user execute, [3] supervisor read, [4] supervisor write, [5] supervisor execute. User state uses [2:0] and supervisor state uses [5:3]. A load needs read, a store needs write and a fetch needs execute. `req_kind` is 0 for load, 1 for store, 2 for fetch, and 3 acts as a load.
- R10: `res_status` is 0 for a grant, 1 for a miss, 2 when a load or store lacks its permission, and 3 when a fetch lacks execute. `res_ra` is 0 unless the access is granted.
- R11: A request with `req_ext` high and `req_kind` equal to fetch raises `res_illegal` and reports a miss with index 0. `res_illegal` is low for every other request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request strobe |
| req_ea | input | EAW | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| req_ext | input | 1 | Use the external context |
| ctx_wide | input | 1 | Full-width address mode |
| ctx_user | input | 1 | User privilege state |
| ctx_ispace | input | 1 | Instruction address space |
| ctx_dspace | input | 1 | Data address space |
| pid0 | input | PIDW | Primary process ID |
| pid1 | input | PIDW | Second process ID, 0 means unused |
| pid2 | input | PIDW | Third process ID, 0 means unused |
| ext_pid | input | PIDW | External-context process ID |
| ext_as | input | 1 | External-context address space |
| ext_user | input | 1 | External-context privilege |
| ent_valid | input | NUM_ENT | Entry valid flags |
| ent_tid | input | NUM_ENT*PIDW | Entry translation IDs |
| ent_ts | input | NUM_ENT | Entry address-space bits |
| ent_size | input | NUM_ENT*SZW | Entry page-size codes |
| ent_epn | input | NUM_ENT*EAW | Entry effective page numbers |
| ent_rpn | input | NUM_ENT*RAW | Entry real page numbers |
| ent_perm | input | NUM_ENT*6 | Entry permission bits |
| res_valid | output | 1 | Result strobe |
| res_status | output | 2 | Outcome code |
| res_index | output | IDXW | Deciding entry |
| res_ra | output | RAW | Real address on a grant |
| res_illegal | output | 1 | External-context fetch was requested |

## Verification
Two functions can meet in one cycle: the priority choice among several matching entries, and the permission check on the chosen entry. The bench sets up cases where a lower entry denies the access and a higher entry would grant it. The result must be the lower entry's violation, not the grant. It also sets up cases where the lower entry is dropped by an address-space mismatch, so the higher entry decides. The permission-bit sweep, the page-size sweep and the process-ID sweep are all judged against an arithmetic model kept in the bench.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
   typedef enum logic [1:0] {
      ST_HIT   = 2'd0,
      ST_MISS  = 2'd1,
      ST_ACCV  = 2'd2,
      ST_EXECV = 2'd3
   } tlbm_status_e;

   localparam logic [1:0] K_LOAD  = 2'd0;
   localparam logic [1:0] K_STORE = 2'd1;
   localparam logic [1:0] K_FETCH = 2'd2;

   localparam int PAGE_LOG2 = 10;
   localparam int PERM_W    = 6;
endpackage

// File: rtl/tlbm_entry_cmp.sv
module tlbm_entry_cmp
   import tlbm_pkg::*;
#(
   parameter int EAW  = 48,
   parameter int RAW  = 40,
   parameter int PIDW = 8,
   parameter int SZW  = 4
) (
   input  logic [EAW-1:0]    ea,
   input  logic [1:0]        kind,
   input  logic              use_ext,
   input  logic              as_bit,
   input  logic              user,
   input  logic [PIDW-1:0]   pid0,
   input  logic [PIDW-1:0]   pid1,
   input  logic [PIDW-1:0]   pid2,
   input  logic [PIDW-1:0]   ext_pid,
   input  logic              e_valid,
   input  logic [PIDW-1:0]   e_tid,
   input  logic              e_ts,
   input  logic [SZW-1:0]    e_size,
   input  logic [EAW-1:0]    e_epn,
   input  logic [RAW-1:0]    e_rpn,
   input  logic [PERM_W-1:0] e_perm,
   output logic              cand,
   output logic              allowed,
   output logic [RAW-1:0]    ra
);
   localparam int SHW = $clog2(EAW) + 1;

   logic [SHW-1:0] shift;
   logic [EAW-1:0] keep_mask;
   logic [RAW-1:0] rmask;
   logic           addr_ok, pid_ok, ts_ok;
   logic [2:0]     rights;

   assign shift     = SHW'(PAGE_LOG2) + SHW'(e_size);
   assign keep_mask = {EAW{1'b1}} << shift;
   assign rmask     = keep_mask[RAW-1:0];
   assign addr_ok   = ((ea ^ e_epn) & keep_mask) == '0;
   assign ts_ok     = (e_ts == as_bit);

   always_comb begin
      if (e_tid == '0)
         pid_ok = 1'b1;
      else if (use_ext)
         pid_ok = (e_tid == ext_pid);
      else
         pid_ok = (e_tid == pid0)
                | ((pid1 != '0) & (e_tid == pid1))
                | ((pid2 != '0) & (e_tid == pid2));
   end

   assign cand   = e_valid & addr_ok & pid_ok & ts_ok;
   assign rights = user ? e_perm[2:0] : e_perm[5:3];

   always_comb begin
      case (kind)
         K_STORE: allowed = rights[1];
         K_FETCH: allowed = rights[2];
         default: allowed = rights[0];
      endcase
   end

   assign ra = (e_rpn & rmask) | (ea[RAW-1:0] & ~rmask);
endmodule

// File: rtl/tlbm_first_pick.sv
module tlbm_first_pick #(
   parameter int N    = 4,
   parameter int IDXW = 2
) (
   input  logic [N-1:0]    cand,
   output logic            found,
   output logic [IDXW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand[i]) idx = IDXW'(i);
      end
   end
   assign found = |cand;
endmodule

// File: rtl/tlb_mas_match.sv
module tlb_mas_match
   import tlbm_pkg::*;
#(
   parameter int NUM_ENT = 4,
   parameter int EAW     = 48,
   parameter int RAW     = 40,
   parameter int PIDW    = 8,
   parameter int SZW     = 4,
   localparam int IDXW   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [EAW-1:0]              req_ea,
   input  logic [1:0]                  req_kind,
   input  logic                        req_ext,
   input  logic                        ctx_wide,
   input  logic                        ctx_user,
   input  logic                        ctx_ispace,
   input  logic                        ctx_dspace,
   input  logic [PIDW-1:0]             pid0,
   input  logic [PIDW-1:0]             pid1,
   input  logic [PIDW-1:0]             pid2,
   input  logic [PIDW-1:0]             ext_pid,
   input  logic                        ext_as,
   input  logic                        ext_user,
   input  logic [NUM_ENT-1:0]          ent_valid,
   input  logic [NUM_ENT*PIDW-1:0]     ent_tid,
   input  logic [NUM_ENT-1:0]          ent_ts,
   input  logic [NUM_ENT*SZW-1:0]      ent_size,
   input  logic [NUM_ENT*EAW-1:0]      ent_epn,
   input  logic [NUM_ENT*RAW-1:0]      ent_rpn,
   input  logic [NUM_ENT*PERM_W-1:0]   ent_perm,
   output logic                        res_valid,
   output logic [1:0]                  res_status,
   output logic [IDXW-1:0]             res_index,
   output logic [RAW-1:0]              res_ra,
   output logic                        res_illegal
);
   // elaboration-time parameter checks
   if (RAW > EAW) begin : g_bad_raw
      $error("RAW must not exceed EAW");
   end
   if (EAW < PAGE_LOG2 + (1 << SZW)) begin : g_bad_eaw
      $error("EAW too small for the largest page size");
   end
   if (RAW <= PAGE_LOG2) begin : g_bad_small
      $error("RAW must exceed the smallest page offset");
   end

   logic [EAW-1:0] ea_eff;
   logic           is_fetch, illegal, as_bit, user_eff;
   logic [NUM_ENT-1:0] cand, allow;
   logic [RAW-1:0] ra_all [NUM_ENT];
   logic           found;
   logic [IDXW-1:0] sel;

   tlbm_status_e   st_n;
   logic [RAW-1:0] ra_n;
   logic [IDXW-1:0] idx_n;

   if (EAW > 32) begin : g_trunc
      assign ea_eff = ctx_wide ? req_ea : {{(EAW-32){1'b0}}, req_ea[31:0]};
   end else begin : g_notrunc
      assign ea_eff = req_ea;
   end

   assign is_fetch = (req_kind == K_FETCH);
   assign illegal  = req_ext & is_fetch;
   assign as_bit   = is_fetch ? ctx_ispace : (req_ext ? ext_as : ctx_dspace);
   assign user_eff = req_ext ? ext_user : ctx_user;

   for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      tlbm_entry_cmp #(.EAW(EAW), .RAW(RAW), .PIDW(PIDW), .SZW(SZW)) u_cmp (
         .ea      (ea_eff),
         .kind    (req_kind),
         .use_ext (req_ext),
         .as_bit  (as_bit),
         .user    (user_eff),
         .pid0    (pid0),
         .pid1    (pid1),
         .pid2    (pid2),
         .ext_pid (ext_pid),
         .e_valid (ent_valid[e]),
         .e_tid   (ent_tid[e*PIDW +: PIDW]),
         .e_ts    (ent_ts[e]),
         .e_size  (ent_size[e*SZW +: SZW]),
         .e_epn   (ent_epn[e*EAW +: EAW]),
         .e_rpn   (ent_rpn[e*RAW +: RAW]),
         .e_perm  (ent_perm[e*PERM_W +: PERM_W]),
         .cand    (cand[e]),
         .allowed (allow[e]),
         .ra      (ra_all[e])
      );
   end

   tlbm_first_pick #(.N(NUM_ENT), .IDXW(IDXW)) u_pick (
      .cand  (cand),
      .found (found),
      .idx   (sel)
   );

   always_comb begin
      st_n  = ST_MISS;
      ra_n  = '0;
      idx_n = '0;
      if (!illegal && found) begin
         idx_n = sel;
         if (allow[sel]) begin
            st_n = ST_HIT;
            ra_n = ra_all[sel];
         end else begin
            st_n = is_fetch ? ST_EXECV : ST_ACCV;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_status  <= ST_MISS;
         res_index   <= '0;
         res_ra      <= '0;
         res_illegal <= 1'b0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) begin
            res_status  <= st_n;
            res_index   <= idx_n;
            res_ra      <= ra_n;
            res_illegal <= illegal;
         end
      end
   end
endmodule

// File: rtl/tlb_mas_match_chk.sv
module tlb_mas_match_chk
   import tlbm_pkg::*;
#(
   parameter int EAW  = 48,
   parameter int RAW  = 40
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req_valid,
   input logic [EAW-1:0] req_ea,
   input logic [1:0]     req_kind,
   input logic           req_ext,
   input logic           res_valid,
   input logic [1:0]     res_status,
   input logic [RAW-1:0] res_ra,
   input logic           res_illegal
);
   p_resp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);

   p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);

   p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (res_status != ST_HIT || res_ra[PAGE_LOG2-1:0] == $past(req_ea[PAGE_LOG2-1:0])));

   p_ra_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (res_status == ST_HIT || res_ra == '0));

   p_exec_fetch_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind != K_FETCH) |=> res_status != ST_EXECV);

   p_illegal_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ext && req_kind == K_FETCH) |=> (res_illegal && res_status == ST_MISS));

   p_legal_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !(req_ext && req_kind == K_FETCH)) |=> !res_illegal);
endmodule

bind tlb_mas_match tlb_mas_match_chk #(.EAW(EAW), .RAW(RAW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ea      (req_ea),
   .req_kind    (req_kind),
   .req_ext     (req_ext),
   .res_valid   (res_valid),
   .res_status  (res_status),
   .res_ra      (res_ra),
   .res_illegal (res_illegal)
);

// File: tb/tlb_mas_match_test.sv
module tlb_mas_match_test;
   localparam int N = 4, EAW = 48, RAW = 40, PIDW = 8, SZW = 4;

   logic clk = 0, rst_n = 0;
   always #5ns clk = ~clk;

   logic            req_valid = 0, req_ext = 0;
   logic [EAW-1:0]  r_ea = '0;
   logic [1:0]      r_kind = 0;
   logic            c_wide = 1, c_user = 0, c_is = 0, c_ds = 0;
   logic [PIDW-1:0] p0 = 0, p1 = 0, p2 = 0, x_pid = 0;
   logic            x_as = 0, x_user = 0;

   logic            e_valid [N];
   logic [PIDW-1:0] e_tid [N];
   logic            e_ts [N];
   logic [SZW-1:0]  e_size [N];
   logic [EAW-1:0]  e_epn [N];
   logic [RAW-1:0]  e_rpn [N];
   logic [5:0]      e_perm [N];

   logic [N-1:0]      f_valid, f_ts;
   logic [N*PIDW-1:0] f_tid;
   logic [N*SZW-1:0]  f_size;
   logic [N*EAW-1:0]  f_epn;
   logic [N*RAW-1:0]  f_rpn;
   logic [N*6-1:0]    f_perm;

   always_comb begin
      for (int e = 0; e < N; e++) begin
         f_valid[e] = e_valid[e];
         f_ts[e]    = e_ts[e];
         f_tid[e*PIDW +: PIDW] = e_tid[e];
         f_size[e*SZW +: SZW]  = e_size[e];
         f_epn[e*EAW +: EAW]   = e_epn[e];
         f_rpn[e*RAW +: RAW]   = e_rpn[e];
         f_perm[e*6 +: 6]      = e_perm[e];
      end
   end

   logic           res_valid, res_illegal;
   logic [1:0]     res_status, res_index;
   logic [RAW-1:0] res_ra;

   tlb_mas_match #(.NUM_ENT(N), .EAW(EAW), .RAW(RAW), .PIDW(PIDW), .SZW(SZW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(r_ea), .req_kind(r_kind),
      .req_ext(req_ext), .ctx_wide(c_wide), .ctx_user(c_user), .ctx_ispace(c_is),
      .ctx_dspace(c_ds), .pid0(p0), .pid1(p1), .pid2(p2), .ext_pid(x_pid), .ext_as(x_as),
      .ext_user(x_user), .ent_valid(f_valid), .ent_tid(f_tid), .ent_ts(f_ts),
      .ent_size(f_size), .ent_epn(f_epn), .ent_rpn(f_rpn), .ent_perm(f_perm),
      .res_valid(res_valid), .res_status(res_status), .res_index(res_index),
      .res_ra(res_ra), .res_illegal(res_illegal)
   );

   int n_run = 0, n_fail = 0;

   function automatic void model(output logic [1:0] st, output logic [1:0] ix,
                                 output logic [RAW-1:0] ra, output logic ill);
      logic [63:0] ea, page, off;
      logic        found, ok, asb, usr;
      int          f, k, bp;
      ea = {16'b0, r_ea};
      if (!c_wide) ea = ea % 64'h1_0000_0000;
      ill = req_ext && r_kind == 2;
      st = 1; ix = 0; ra = '0; found = 0; f = 0;
      if (ill) return;
      asb = (r_kind == 2) ? c_is : (req_ext ? x_as : c_ds);
      for (int e = 0; e < N; e++) begin
         page = 64'd1024 << e_size[e];
         if (e_tid[e] == 0) ok = 1;
         else if (req_ext) ok = (e_tid[e] == x_pid);
         else ok = (e_tid[e] == p0) || (p1 != 0 && e_tid[e] == p1) || (p2 != 0 && e_tid[e] == p2);
         if (!found && e_valid[e] && ok && e_ts[e] == asb &&
             (ea / page) == ({16'b0, e_epn[e]} / page)) begin
            found = 1; f = e;
         end
      end
      if (!found) return;
      ix = 2'(f);
      page = 64'd1024 << e_size[f];
      usr = req_ext ? x_user : c_user;
      k = (r_kind == 1) ? 1 : (r_kind == 2) ? 2 : 0;
      bp = usr ? k : 3 + k;
      if (e_perm[f][bp]) begin
         st = 0;
         off = ea % page;
         ra = RAW'((({24'b0, e_rpn[f]} / page) * page) + off);
      end else begin
         st = (r_kind == 2) ? 3 : 2;
      end
   endfunction

   task automatic run(input string tag);
      logic [1:0] es, ei; logic [RAW-1:0] er; logic eil;
      @(negedge clk); req_valid = 1;
      @(negedge clk); req_valid = 0;
      model(es, ei, er, eil);
      n_run++;
      if (res_valid !== 1'b1 || res_status !== es || res_index !== ei ||
          res_ra !== er || res_illegal !== eil) begin
         n_fail++;
         $display("FAIL %s: got v=%0b st=%0d ix=%0d ra=%h ill=%0b, expected v=1 st=%0d ix=%0d ra=%h ill=%0b",
                  tag, res_valid, res_status, res_index, res_ra, res_illegal, es, ei, er, eil);
      end
   endtask

   task automatic clear_ents();
      for (int e = 0; e < N; e++) begin
         e_valid[e] = 0; e_tid[e] = 0; e_ts[e] = 0; e_size[e] = 0;
         e_epn[e] = '0; e_rpn[e] = '0; e_perm[e] = 6'h3F;
      end
      req_ext = 0; c_wide = 1; c_user = 0; c_is = 0; c_ds = 0;
      p0 = 0; p1 = 0; p2 = 0; x_pid = 0; x_as = 0; x_user = 0;
   endtask

   task automatic one_ent(input logic [EAW-1:0] epn, input logic [RAW-1:0] rpn);
      clear_ents();
      e_valid[0] = 1; e_epn[0] = epn; e_rpn[0] = rpn;
   endtask

   initial begin
      #2_000_000ns;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      clear_ents();
      repeat (3) @(negedge clk);
      n_run++;
      if (res_valid !== 0 || res_illegal !== 0) begin
         n_fail++;
         $display("FAIL R1 reset: got v=%0b ill=%0b, expected 0 0", res_valid, res_illegal);
      end
      rst_n = 1;
      @(negedge clk);

      // R9 R10: permission sweep
      one_ent(48'h1000, 40'h5000);
      r_ea = 48'h1234;
      for (int pm = 0; pm < 64; pm++)
         for (int kd = 0; kd < 4; kd++)
            for (int us = 0; us < 2; us++) begin
               e_perm[0] = 6'(pm); r_kind = 2'(kd); c_user = us[0];
               run("R9 R10 perm");
            end

      // R1: idle cycle after a request
      @(negedge clk);
      n_run++;
      if (res_valid !== 0) begin
         n_fail++;
         $display("FAIL R1 idle: got v=%0b, expected 0", res_valid);
      end

      // R2: page size sweep
      r_kind = 0;
      for (int s = 0; s < 16; s++) begin
         one_ent(48'h3C_5A00_0000, 40'h7_1230_0000);
         e_size[0] = 4'(s);
         r_ea = 48'h3C_5A00_0000 + (48'd1024 << s) - 48'd4;  run("R2 top of page");
         r_ea = 48'h3C_5A00_0000 + 48'd20;                   run("R2 low offset");
         r_ea = 48'h3C_5A00_0000 + (48'd1024 << s);          run("R2 next page");
         r_ea = 48'h3C_5A00_0000 - 48'd1;                    run("R2 prev page");
      end

      // R3: narrow address mode
      one_ent(48'h0000_8000_0000, 40'h00_1234_5000);
      e_size[0] = 4'd2;
      r_ea = 48'hAB_8000_0010;
      c_wide = 0; run("R3 narrow hit");
      c_wide = 1; run("R3 wide miss");
      e_epn[0] = 48'hAB_8000_0000;
      c_wide = 0; run("R3 narrow miss");
      c_wide = 1; run("R3 wide hit");

      // R4 R5: PID sweep
      one_ent(48'h1000, 40'h5000);
      r_ea = 48'h1234;
      for (int t = 0; t < 4; t++)
         for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
               for (int c = 0; c < 4; c++) begin
                  e_tid[0] = PIDW'(t); p0 = PIDW'(a); p1 = PIDW'(b); p2 = PIDW'(c);
                  run("R4 R5 pid");
               end

      // R6: external context
      one_ent(48'h1000, 40'h5000);
      r_ea = 48'h1234; e_tid[0] = 8'd5; e_perm[0] = 6'b000001;
      p0 = 8'd1; x_pid = 8'd5; c_user = 0; x_user = 1;
      req_ext = 1; r_kind = 0; run("R6 ext user read");
      r_kind = 1;              run("R6 ext user write denied");
      req_ext = 0; r_kind = 0; run("R6 normal ctx miss");
      p0 = 8'd5;               run("R6 normal supervisor denied");
      p0 = 8'd3; p1 = 8'd5; p2 = 8'd5; x_pid = 8'd6;
      req_ext = 1;             run("R6 pids ignored");
      x_pid = 8'd5; e_ts[0] = 1; x_as = 1; c_ds = 0;
      run("R6 ext as");
      x_as = 0; c_ds = 1;      run("R6 ds ignored");

      // R7: address space, fetch vs data
      clear_ents();
      r_ea = 48'h2200;
      for (int e = 0; e < 2; e++) begin
         e_valid[e] = 1; e_epn[e] = 48'h2000; e_size[e] = 4'd1;
         e_rpn[e] = (e == 0) ? 40'hA000 : 40'hB000;
      end
      e_ts[0] = 1; e_ts[1] = 0;
      r_kind = 2; c_is = 0; c_ds = 1; run("R7 fetch is0");
      c_is = 1; c_ds = 0;             run("R7 fetch is1");
      r_kind = 0; c_ds = 1; c_is = 0; run("R7 data ds1");
      c_ds = 0; c_is = 1;             run("R7 data ds0");

      // R8: priority with permission outcomes
      clear_ents();
      r_ea = 48'h4100;
      for (int e = 0; e < N; e++) begin
         e_epn[e] = 48'h4000; e_size[e] = 4'd2; e_rpn[e] = 40'(e + 1) << 20;
      end
      e_valid[0] = 0; e_valid[1] = 1; e_valid[2] = 1; e_valid[3] = 1;
      e_perm[1] = 6'b000000; e_perm[2] = 6'h3F;
      r_kind = 0; run("R8 lower denies");
      r_kind = 2; run("R8 lower denies exec");
      e_perm[1] = 6'b100000; run("R8 lower grants exec");
      e_valid[1] = 0; e_perm[2] = 6'b011111; run("R8 exec violation idx2");
      e_valid[2] = 0; run("R8 idx3");
      e_valid[3] = 0; run("R8 none valid");
      e_valid[0] = 1; e_tid[0] = 8'd9; p0 = 8'd1; run("R8 pid excluded");

      // R11: external fetch is illegal
      one_ent(48'h1000, 40'h5000);
      r_ea = 48'h1234; req_ext = 1;
      r_kind = 2; run("R11 ext fetch");
      r_kind = 0; run("R11 ext load legal");
      req_ext = 0; r_kind = 2; run("R11 normal fetch");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule